// File: doc/BRIEF.md
# Shared Shift-Add Luma Fractional Sample Filter

This block computes one fractional-position luma sample from a row or column of eight integer-position reference samples. A single datapath of shifts and additions, with no multiplier, serves the quarter-position filter and the half-position filter. The three-quarter filter is not built separately. The quarter-position hardware produces it by taking the eight samples in reverse order. A two-bit type code picks the filter on every cycle. Any mix of types may therefore stream through at one sample per cycle.

The inputs are signed so that a second, vertical pass can take the unrounded outputs of a first, horizontal pass. The result is the raw weighted sum, scaled by 64 relative to the input samples. Rounding, clipping and weighted prediction are left to later logic. The pipeline has two register stages. A valid flag and the type code travel with each result. The reserved type code passes the integer sample through at the same scale, so every sub-pel position, including the full-pel one, leaves the block with the same gain.

Top module: `luma_frac_pe`

## Requirements
- R1: With type code 2'b00 (quarter position), the result equals -s0 + 4*s1 - 10*s2 + 58*s3 + 17*s4 - 5*s5 + s6, where sample k sits at in_smp bits [16k+15:16k].
- R2: With type code 2'b01 (half position), the result equals -s0 + 4*s1 - 11*s2 + 40*s3 + 40*s4 - 11*s5 + 4*s6 - s7.
- R3: With type code 2'b10 (three-quarter position), the result equals the quarter-position result taken on the samples in reverse order: s1 - 5*s2 + 17*s3 + 58*s4 - 10*s5 + 4*s6 - s7. Sample 0 has no effect on it.
- R4: With type code 2'b11, the result equals s3 multiplied by 64, sign preserved.
- R5: A sample accepted with in_valid high at a rising edge appears with out_valid high exactly two rising edges later. out_valid is low in every other cycle. Back-to-back inputs give back-to-back outputs.
- R6: out_type shows the type code of the sample whose result is on out_sum while out_valid is high.
- R7: While rst_n is low, and after it is released until the first valid result, out_valid is low.
- R8: Full-scale signed inputs of either sign give the exact sum for every type, with no wrap in the 24-bit output.
- R9: With type code 2'b00, sample 7 has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input samples and type are valid this cycle |
| in_type | input | 2 | Filter type: 00 quarter, 01 half, 10 three-quarter, 11 integer |
| in_smp | input | 128 | Eight signed 16-bit samples; sample k at bits [16k+15:16k] |
| out_valid | output | 1 | out_sum and out_type are valid |
| out_type | output | 2 | Type code carried with the result |
| out_sum | output | 24 | Signed unrounded filter sum |

## Verification
Each stage holds only partial sums, a valid bit and a type tag. A corrupted partial sum or a wrong term selection therefore shows up as a wrong out_sum exactly two cycles after the input. The error is usually off by a multiple of a single tap weight, which points to the faulty term. A slip in the valid or tag pipeline shows at the ports in that same cycle: a result appears one cycle early or late, or carries the wrong type. Mixed-type back-to-back streams expose any state that leaks from one sample into the next.

// File: rtl/luma_frac_pe.sv
module luma_frac_pe #(
  parameter int SW = 16,
  parameter int OW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           in_type,
  input  logic [8*SW-1:0]      in_smp,
  output logic                 out_valid,
  output logic [1:0]           out_type,
  output logic signed [OW-1:0] out_sum
);
  localparam int NT = 8;
  localparam logic [1:0] T_QTR = 2'b00;
  localparam logic [1:0] T_HALF = 2'b01;
  localparam logic [1:0] T_3QTR = 2'b10;

  logic signed [OW-1:0] s [NT];
  logic signed [OW-1:0] x [NT];
  logic rev;

  assign rev = (in_type == T_3QTR);

  for (genvar k = 0; k < NT; k++) begin : g_tap
    assign s[k] = OW'($signed(in_smp[k*SW +: SW]));
    assign x[k] = rev ? s[NT-1-k] : s[k];
  end

  logic signed [OW-1:0] pr07, pr16, pr25, pr34;
  assign pr07 = x[0] + x[7];
  assign pr16 = x[1] + x[6];
  assign pr25 = x[2] + x[5];
  assign pr34 = x[3] + x[4];

  logic signed [OW-1:0] t0, t1, t2, t3;
  always_comb begin
    case (in_type)
      T_HALF: begin
        t0 = -pr07;
        t1 = pr16 <<< 2;
        t2 = -((pr25 <<< 3) + (pr25 <<< 1) + pr25);
        t3 = (pr34 <<< 5) + (pr34 <<< 3);
      end
      T_QTR, T_3QTR: begin
        t0 = x[6] - x[0];
        t1 = (x[1] <<< 2) - ((x[2] <<< 3) + (x[2] <<< 1));
        t2 = (x[3] <<< 6) - ((x[3] <<< 2) + (x[3] <<< 1));
        t3 = ((x[4] <<< 4) + x[4]) - ((x[5] <<< 2) + x[5]);
      end
      default: begin
        t0 = '0;
        t1 = '0;
        t2 = s[3] <<< 6;
        t3 = '0;
      end
    endcase
  end

  logic signed [OW-1:0] p0, p1, p2, p3;
  logic                 p_vld;
  logic [1:0]           p_typ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_vld <= 1'b0;
      p_typ <= '0;
      p0 <= '0;
      p1 <= '0;
      p2 <= '0;
      p3 <= '0;
    end else begin
      p_vld <= in_valid;
      p_typ <= in_type;
      p0 <= t0 + t1;
      p1 <= t2;
      p2 <= t3;
      p3 <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_type  <= '0;
      out_sum   <= '0;
    end else begin
      out_valid <= p_vld;
      out_type  <= p_typ;
      out_sum   <= (p0 + p1) + (p2 + p3);
    end
  end

  logic signed [OW-1:0] chk_mid;
  assign chk_mid = OW'($signed(in_smp[3*SW +: SW]));

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> out_valid == $past(in_valid, 2)); // R5
  AST_TYPE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_type == $past(in_type, 2)); // R6
  AST_INTEGER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_type == 2'b11) |-> out_sum == ($past(chk_mid, 2) <<< 6)); // R4
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid); // R7
  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n)) |-> !out_valid); // R7
endmodule

// File: tb/luma_frac_pe_tb_top.sv
`timescale 1ns/1ps
module luma_frac_pe_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_type = 2'b00;
  logic [127:0] in_smp = '0;
  logic out_valid;
  logic [1:0] out_type;
  logic signed [23:0] out_sum;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  luma_frac_pe dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type),
    .in_smp(in_smp), .out_valid(out_valid), .out_type(out_type), .out_sum(out_sum)
  );

  function automatic int coef(input logic [1:0] t, input int k);
    int qa [8] = '{-1, 4, -10, 58, 17, -5, 1, 0};
    int hb [8] = '{-1, 4, -11, 40, 40, -11, 4, -1};
    case (t)
      2'b00: return qa[k];
      2'b01: return hb[k];
      2'b10: return qa[7-k];
      default: return (k == 3) ? 64 : 0;
    endcase
  endfunction

  function automatic logic [23:0] ref_sum(input logic [1:0] t, input int v [8]);
    int acc = 0;
    for (int k = 0; k < 8; k++) acc += coef(t, k) * v[k];
    return 24'(acc);
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] t, input int v [8]);
    in_type = t;
    for (int k = 0; k < 8; k++) in_smp[16*k +: 16] = 16'(v[k]);
  endtask

  function automatic int pat(input int seed, input int k);
    return ((seed * 7919 + k * 10457 + seed * k * 31) % 65536) - 32768;
  endfunction

  task automatic one_shot(input string req, input logic [1:0] t, input int v [8]);
    @(negedge clk);
    load(t, v);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " not valid early"}, 24'(out_valid), 24'd0);
    @(negedge clk);
    check({req, " valid"}, 24'(out_valid), 24'd1);
    check({req, " type"}, 24'(out_type), 24'(t));
    check(req, out_sum, ref_sum(t, v));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 during reset", 24'(out_valid), 24'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 after release", 24'(out_valid), 24'd0);
    @(negedge clk);
    check("R7 idle", 24'(out_valid), 24'd0);
  endtask

  task automatic t_types;
    int v [8];
    for (int s = 1; s <= 3; s++) begin
      for (int k = 0; k < 8; k++) v[k] = pat(s, k);
      one_shot("R1", 2'b00, v);
      one_shot("R2", 2'b01, v);
      one_shot("R3", 2'b10, v);
      one_shot("R4", 2'b11, v);
    end
    v = '{0, 0, 0, 1, 0, 0, 0, 0};
    one_shot("R1 impulse", 2'b00, v);
    one_shot("R3 impulse", 2'b10, v);
  endtask

  task automatic t_ignore;
    int v [8];
    logic [23:0] r_a, r_c;
    for (int k = 0; k < 8; k++) v[k] = pat(9, k);
    one_shot("R9 base", 2'b00, v);
    r_a = out_sum;
    v[7] = 31000;
    one_shot("R9 s7 changed", 2'b00, v);
    check("R9 unchanged", out_sum, r_a);
    one_shot("R3 base", 2'b10, v);
    r_c = out_sum;
    v[0] = -29000;
    one_shot("R3 s0 changed", 2'b10, v);
    check("R3 s0 unchanged", out_sum, r_c);
  endtask

  task automatic t_extremes;
    int v [8];
    for (int t = 0; t < 4; t++) begin
      for (int k = 0; k < 8; k++) v[k] = (coef(2'(t), k) >= 0) ? 32767 : -32768;
      one_shot("R8 max", 2'(t), v);
      for (int k = 0; k < 8; k++) v[k] = (coef(2'(t), k) >= 0) ? -32768 : 32767;
      one_shot("R8 min", 2'(t), v);
    end
  endtask

  task automatic t_stream;
    int vs [16][8];
    logic [1:0] ts [16];
    logic vl [16];
    int cur [8];
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 8; k++) vs[i][k] = pat(40 + i, k);
      ts[i] = 2'(i * 3 + i / 4);
      vl[i] = (i % 5) != 3;
    end
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R5 stream valid", 24'(out_valid), 24'(vl[i-2]));
        if (vl[i-2]) begin
          cur = vs[i-2];
          check("R6 stream type", 24'(out_type), 24'(ts[i-2]));
          check("R5 stream sum", out_sum, ref_sum(ts[i-2], cur));
        end
      end
      if (i < 16) begin
        cur = vs[i];
        load(ts[i], cur);
        in_valid = vl[i];
      end else in_valid = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_types();
    t_ignore();
    t_extremes();
    t_stream();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule